// File: doc/BRIEF.md
# Traffic Engine Task and Result Register Bank

This block is the host-facing register file for a group of memory traffic engines. Each engine gets two 256-bit task descriptors, one for its read side and one for its write side. A descriptor holds the working-set size, the stride, the transaction count, the burst size and the start address. The host programs the descriptors over a 32-bit word interface. A descriptor takes its new value atomically when its top word is written. The descriptors drive the engines continuously.

Once every descriptor is programmed, the host writes a single control word. This sends a one-cycle start pulse to every engine that is not busy. When an engine reports completion, its 64-bit elapsed-cycle result is captured into a per-engine status register and its done flag is set. The host can read the status register and the done flag. The next start that reaches that engine clears its done flag.

Word addresses are `{global, engine, slot}`. The slot is 5 bits wide and the engine field is ENG_W bits wide. With the default of four engines the address is 8 bits.

Top module: `bench_param_bank`

## Requirements
- R1: Reset clears every task descriptor, status register and done flag, and holds `eng_start` at zero. All readable words return zero after reset.
- R2: Within a descriptor, slot word k carries bits [32k+31:32k]. The field layout is: working-set size bits [31:0] (word 0), stride [63:32] (word 1), transaction count [127:64] (words 2 and 3), burst size [159:128] (word 4), start address [223:160] (words 5 and 6), and reserved [255:224] (word 7). Reading a slot word returns the committed descriptor word.
- R3: Writing any of words 0 to 6 changes neither the readback nor the engine-facing descriptor. Writing word 7 commits all eight words together on that clock edge.
- R4: The reserved word reads back as zero and drives zero to the engine, whatever value was written to it.
- R5: Slots 0 to 7 address the read-side descriptor and slots 8 to 15 address the write-side descriptor of the engine named by the engine field. A write never alters another engine's descriptors or the other side's descriptor.
- R6: Writing a value with bit 0 set to global word 0 (address with the top bit 1 and all other bits 0) produces `eng_start` high for exactly one cycle, the cycle after the write, on every engine whose `eng_busy` was low at the write.
- R7: An engine whose `eng_busy` is high at the start write receives no pulse and keeps its done flag.
- R8: A high `eng_done[e]` captures `eng_result` slice e into status slots 16 (low 32 bits) and 17 (high 32 bits) of engine e, and sets bit e of global word 0 on read, from the next cycle.
- R9: A start pulse delivered to an engine clears its done flag but leaves its status value unchanged.
- R10: If a start pulse and `eng_done` reach the same engine in the same cycle, the done flag ends cleared and the result is still captured.
- R11: Writes to status slots, to unmapped slots, to global words other than word 0, or to global word 0 with bit 0 clear have no effect, and unmapped words read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Word address {global, engine, slot} |
| host_wr | input | 1 | Write strobe for one word |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| eng_rd_task | output | NUM_ENG*256 | Read-side descriptors, engine e at bits [256e+255:256e] |
| eng_wr_task | output | NUM_ENG*256 | Write-side descriptors, same packing |
| eng_start | output | NUM_ENG | One-cycle start pulse per engine |
| eng_busy | input | NUM_ENG | Engine is running and ignores start |
| eng_done | input | NUM_ENG | Completion pulse carrying a valid result |
| eng_result | input | NUM_ENG*64 | Elapsed-cycle result, engine e at bits [64e+63:64e] |

## Verification
The start pulse that clears an engine's done flag and that engine's completion report can land on the same clock edge. The bench provokes this by raising `eng_done` for one engine in exactly the cycle the broadcast pulse is on `eng_start`. It then reads back both the done flags and that engine's status words. The outcome is correct when the flag is clear and the status holds the newly reported result. A checker property also requires every delivered pulse to leave the flag low on the following cycle.

// File: rtl/bench_bank_pkg.sv
package bench_bank_pkg;
   localparam int HOST_DW    = 32;
   localparam int TASK_W     = 256;
   localparam int TASK_WORDS = TASK_W / HOST_DW;
   localparam int STAT_W     = 64;
   localparam int SLOT_W     = 5;

   // descriptor layout, least significant field first in host word order
   typedef struct packed {
      logic [31:0] rsvd;
      logic [63:0] base;
      logic [31:0] burst;
      logic [63:0] count;
      logic [31:0] stride;
      logic [31:0] wset;
   } task_t;

   function automatic task_t scrub_rsvd(input logic [TASK_W-1:0] raw);
      task_t t;
      t      = task_t'(raw);
      t.rsvd = '0;
      return t;
   endfunction
endpackage

// File: rtl/brb_task_reg.sv
module brb_task_reg
   import bench_bank_pkg::*;
#(
   parameter int WORDS = TASK_WORDS,
   parameter int DW    = HOST_DW,
   localparam int IW   = $clog2(WORDS),
   localparam int LAST = WORDS - 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [IW-1:0] word_sel,
   input  logic [DW-1:0] wdata,
   output task_t         live_o
);
   if (WORDS * DW != TASK_W) begin : g_bad_geom
      $error("descriptor geometry does not match TASK_W");
   end

   logic [LAST*DW-1:0] shadow_q;
   task_t              live_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         live_q   <= '0;
      end else if (wr_en) begin
         if (word_sel == IW'(LAST))
            live_q <= scrub_rsvd({wdata, shadow_q});
         else
            shadow_q[word_sel*DW +: DW] <= wdata;
      end
   end

   assign live_o = live_q;
endmodule

// File: rtl/brb_status_slot.sv
module brb_status_slot
   import bench_bank_pkg::*;
#(
   parameter int RW = STAT_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_hit,
   input  logic          done_in,
   input  logic [RW-1:0] result_in,
   output logic          done_o,
   output logic [RW-1:0] result_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         result_o <= '0;
      end else begin
         if (done_in)   result_o <= result_in;
         if (start_hit) done_o   <= 1'b0;
         else if (done_in) done_o <= 1'b1;
      end
   end
endmodule

// File: rtl/brb_start_ctl.sv
module brb_start_ctl #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         fire,
   input  logic [N-1:0] busy,
   output logic [N-1:0] start_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) start_o <= '0;
      else        start_o <= fire ? ~busy : '0;
   end
endmodule

// File: rtl/bench_param_bank.sv
module bench_param_bank
   import bench_bank_pkg::*;
#(
   parameter int NUM_ENG = 4,
   parameter int ENG_W   = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1,
   parameter int ADDR_W  = ENG_W + SLOT_W + 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         host_addr,
   input  logic                      host_wr,
   input  logic [HOST_DW-1:0]        host_wdata,
   output logic [HOST_DW-1:0]        host_rdata,
   output logic [NUM_ENG*TASK_W-1:0] eng_rd_task,
   output logic [NUM_ENG*TASK_W-1:0] eng_wr_task,
   output logic [NUM_ENG-1:0]        eng_start,
   input  logic [NUM_ENG-1:0]        eng_busy,
   input  logic [NUM_ENG-1:0]        eng_done,
   input  logic [NUM_ENG*STAT_W-1:0] eng_result
);
   localparam int WSEL_W = $clog2(TASK_WORDS);

   if (NUM_ENG < 1 || NUM_ENG > HOST_DW) begin : g_bad_count
      $error("NUM_ENG must lie between 1 and the host word width");
   end
   if (ADDR_W != ENG_W + SLOT_W + 1) begin : g_bad_addr
      $error("ADDR_W must equal ENG_W + SLOT_W + 1");
   end

   // address decode
   logic              is_glob;
   logic [ENG_W-1:0]  eng_sel;
   logic [SLOT_W-1:0] slot;
   logic              eng_ok;
   logic              fire;

   assign is_glob = host_addr[ADDR_W-1];
   assign eng_sel = host_addr[SLOT_W +: ENG_W];
   assign slot    = host_addr[SLOT_W-1:0];
   assign eng_ok  = (32'(eng_sel) < 32'(NUM_ENG));
   assign fire    = host_wr && is_glob && (host_addr[ADDR_W-2:0] == '0) && host_wdata[0];

   logic [TASK_W-1:0] rd_live [NUM_ENG];
   logic [TASK_W-1:0] wr_live [NUM_ENG];
   logic [STAT_W-1:0] stat_q  [NUM_ENG];
   logic [NUM_ENG-1:0] done_vec;

   brb_start_ctl #(.N(NUM_ENG)) u_start (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .busy    (eng_busy),
      .start_o (eng_start)
   );

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
      logic  hit;
      task_t rd_t, wr_t;

      assign hit = host_wr && !is_glob && (32'(eng_sel) == 32'(e));

      brb_task_reg u_rd (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (hit && slot[4:3] == 2'b00),
         .word_sel (slot[WSEL_W-1:0]),
         .wdata    (host_wdata),
         .live_o   (rd_t)
      );

      brb_task_reg u_wr (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (hit && slot[4:3] == 2'b01),
         .word_sel (slot[WSEL_W-1:0]),
         .wdata    (host_wdata),
         .live_o   (wr_t)
      );

      brb_status_slot u_stat (
         .clk       (clk),
         .rst_n     (rst_n),
         .start_hit (eng_start[e]),
         .done_in   (eng_done[e]),
         .result_in (eng_result[e*STAT_W +: STAT_W]),
         .done_o    (done_vec[e]),
         .result_o  (stat_q[e])
      );

      assign rd_live[e] = rd_t;
      assign wr_live[e] = wr_t;
      assign eng_rd_task[e*TASK_W +: TASK_W] = rd_t;
      assign eng_wr_task[e*TASK_W +: TASK_W] = wr_t;
   end

   // read mux
   always_comb begin
      host_rdata = '0;
      if (is_glob) begin
         if (host_addr[ADDR_W-2:0] == '0)
            host_rdata[NUM_ENG-1:0] = done_vec;
      end else if (eng_ok) begin
         case (slot[4:3])
            2'b00: host_rdata = rd_live[eng_sel][slot[WSEL_W-1:0]*HOST_DW +: HOST_DW];
            2'b01: host_rdata = wr_live[eng_sel][slot[WSEL_W-1:0]*HOST_DW +: HOST_DW];
            2'b10: begin
               if (slot[2:0] == 3'd0)      host_rdata = stat_q[eng_sel][HOST_DW-1:0];
               else if (slot[2:0] == 3'd1) host_rdata = stat_q[eng_sel][STAT_W-1:HOST_DW];
            end
            default: host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/bench_param_bank_chk.sv
module bench_param_bank_chk
   import bench_bank_pkg::*;
#(
   parameter int NUM_ENG = 4,
   parameter int ADDR_W  = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [ADDR_W-1:0]         host_addr,
   input logic                      host_wr,
   input logic [HOST_DW-1:0]        host_wdata,
   input logic [NUM_ENG*TASK_W-1:0] eng_rd_task,
   input logic [NUM_ENG*TASK_W-1:0] eng_wr_task,
   input logic [NUM_ENG-1:0]        eng_start,
   input logic [NUM_ENG-1:0]        eng_busy,
   input logic [NUM_ENG-1:0]        eng_done,
   input logic [NUM_ENG-1:0]        done_vec
);
   logic commit_wr, start_wr;
   assign commit_wr = host_wr && !host_addr[ADDR_W-1] && !host_addr[4] && (host_addr[2:0] == 3'd7);
   assign start_wr  = host_wr && host_addr[ADDR_W-1] && (host_addr[ADDR_W-2:0] == '0) && host_wdata[0];

   // R3: only a top-word write may move a descriptor
   assert_partial_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_wr |=> ($stable(eng_rd_task) && $stable(eng_wr_task)));

   // R6: every pulse traces back to a start write one cycle earlier
   assert_pulse_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|eng_start) |-> $past(start_wr));

   // R7: a busy engine is skipped
   assert_busy_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> ((eng_start & $past(eng_busy)) == '0));

   for (genvar e = 0; e < NUM_ENG; e++) begin : g_e
      // R4: reserved word stays zero on both sides
      assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (eng_rd_task[e*TASK_W+224 +: 32] == '0) && (eng_wr_task[e*TASK_W+224 +: 32] == '0));

      // R8: completion without a pulse raises the flag
      assert_done_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (eng_done[e] && !eng_start[e]) |=> done_vec[e]);

      // R9 and R10: a delivered pulse leaves the flag low
      assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
         eng_start[e] |=> !done_vec[e]);
   end
endmodule

bind bench_param_bank bench_param_bank_chk #(.NUM_ENG(NUM_ENG), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_addr   (host_addr),
   .host_wr     (host_wr),
   .host_wdata  (host_wdata),
   .eng_rd_task (eng_rd_task),
   .eng_wr_task (eng_wr_task),
   .eng_start   (eng_start),
   .eng_busy    (eng_busy),
   .eng_done    (eng_done),
   .done_vec    (done_vec)
);

// File: tb/tb_bench_param_bank.sv
module tb_bench_param_bank;
   localparam int NE = 4;
   localparam int AW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  host_addr = '0;
   logic           host_wr = 1'b0;
   logic [31:0]    host_wdata = '0;
   logic [31:0]    host_rdata;
   logic [NE*256-1:0] eng_rd_task, eng_wr_task;
   logic [NE-1:0]  eng_start;
   logic [NE-1:0]  eng_busy = '0;
   logic [NE-1:0]  eng_done = '0;
   logic [NE*64-1:0] eng_result = '0;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   bench_param_bank #(.NUM_ENG(NE)) dut (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata),
      .eng_rd_task(eng_rd_task), .eng_wr_task(eng_wr_task),
      .eng_start(eng_start), .eng_busy(eng_busy), .eng_done(eng_done),
      .eng_result(eng_result)
   );

   // entry: {write, requirement number, address, data or expected read}
   localparam int NV = 24;
   localparam logic [44:0] VEC [NV] = '{
      {1'b1, 4'd3,  8'h20, 32'hA0A0_0001},
      {1'b0, 4'd3,  8'h20, 32'h0000_0000},  // R3 not yet committed
      {1'b1, 4'd2,  8'h21, 32'h0000_0040},
      {1'b1, 4'd2,  8'h22, 32'h1111_2222},
      {1'b1, 4'd2,  8'h23, 32'h3333_4444},
      {1'b1, 4'd2,  8'h24, 32'h0000_0020},
      {1'b1, 4'd2,  8'h25, 32'hDEAD_0000},
      {1'b1, 4'd2,  8'h26, 32'h0000_BEEF},
      {1'b0, 4'd3,  8'h26, 32'h0000_0000},  // R3
      {1'b1, 4'd4,  8'h27, 32'hFFFF_FFFF},
      {1'b0, 4'd2,  8'h20, 32'hA0A0_0001},  // R2
      {1'b0, 4'd2,  8'h23, 32'h3333_4444},
      {1'b0, 4'd2,  8'h26, 32'h0000_BEEF},
      {1'b0, 4'd4,  8'h27, 32'h0000_0000},  // R4
      {1'b0, 4'd5,  8'h28, 32'h0000_0000},  // R5 other side
      {1'b0, 4'd5,  8'h40, 32'h0000_0000},  // R5 other engine
      {1'b1, 4'd11, 8'h30, 32'h1234_5678},
      {1'b0, 4'd11, 8'h30, 32'h0000_0000},  // R11 status write ignored
      {1'b1, 4'd11, 8'h3F, 32'h5555_5555},
      {1'b0, 4'd11, 8'h3F, 32'h0000_0000},  // R11 unmapped
      {1'b1, 4'd5,  8'h28, 32'h0000_1000},
      {1'b1, 4'd5,  8'h2F, 32'h0000_CAFE},
      {1'b0, 4'd5,  8'h28, 32'h0000_1000},  // R5 write side
      {1'b0, 4'd2,  8'h21, 32'h0000_0040}   // R2 read side intact
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #1_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      host_read(8'h80, rd);  check("R1 done flags", rd, 0);
      host_read(8'h20, rd);  check("R1 task word", rd, 0);
      check("R1 start", eng_start, 0);
      check("R1 task bus", {eng_rd_task[255:0], eng_wr_task[255:0]} == '0, 1);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][44]) host_write(VEC[i][39:32], VEC[i][31:0]);
         else begin
            host_read(VEC[i][39:32], rd);
            check($sformatf("R%0d table entry %0d", VEC[i][43:40], i), rd, VEC[i][31:0]);
         end
      end

      // R2 engine-facing field placement for engine 1
      check("R2 wset",   eng_rd_task[256 +: 32],  32'hA0A0_0001);
      check("R2 stride", eng_rd_task[288 +: 32],  32'h40);
      check("R2 count",  eng_rd_task[320 +: 64],  64'h3333_4444_1111_2222);
      check("R2 burst",  eng_rd_task[384 +: 32],  32'h20);
      check("R2 base",   eng_rd_task[416 +: 64],  64'h0000_BEEF_DEAD_0000);
      check("R4 rsvd rd", eng_rd_task[480 +: 32], 0);
      check("R4 rsvd wr", eng_wr_task[480 +: 32], 0);
      check("R5 wr wset", eng_wr_task[256 +: 32], 32'h1000);

      // R3 partial write to engine 2 leaves engine output alone
      host_write(8'h40, 32'h7777_7777);
      check("R3 partial engine bus", eng_rd_task[512 +: 32], 0);

      // R6 broadcast pulse, one cycle
      host_write(8'h80, 32'h1);
      #1 check("R6 pulse", eng_start, 4'hF);
      @(negedge clk); #1 check("R6 single cycle", eng_start, 0);

      // R8 completion capture on engine 2
      @(negedge clk);
      eng_done = 4'b0100; eng_result[128 +: 64] = 64'h0000_00AB_0000_1234;
      @(negedge clk); eng_done = '0;
      host_read(8'h80, rd); check("R8 done flag", rd, 32'h4);
      host_read(8'h50, rd); check("R8 status lo", rd, 32'h1234);
      host_read(8'h51, rd); check("R8 status hi", rd, 32'hAB);

      // R7 and R9: engine 0 done, engine 2 busy during start
      @(negedge clk);
      eng_done = 4'b0001; eng_result[0 +: 64] = 64'h77;
      @(negedge clk); eng_done = '0;
      eng_busy = 4'b0100;
      host_write(8'h80, 32'h1);
      #1 check("R7 busy skipped", eng_start, 4'b1011);
      host_read(8'h80, rd); check("R7 R9 flags", rd, 32'h4);
      host_read(8'h10, rd); check("R9 status kept", rd, 32'h77);
      eng_busy = '0;

      // R10 start and completion on the same edge for engine 1
      host_write(8'h80, 32'h1);
      eng_done = 4'b0010; eng_result[64 +: 64] = 64'h99;
      #1 check("R10 pulse present", eng_start, 4'hF);
      @(negedge clk); eng_done = '0;
      host_read(8'h80, rd); check("R10 flag cleared", rd, 0);
      host_read(8'h30, rd); check("R10 result captured", rd, 32'h99);

      // R11 writes that must not start anything
      host_write(8'h80, 32'h2);
      #1 check("R11 bit0 clear", eng_start, 0);
      host_write(8'h81, 32'h1);
      #1 check("R11 other global", eng_start, 0);

      // R1 reset in mid run
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      host_read(8'h20, rd); check("R1 task after reset", rd, 0);
      host_read(8'h30, rd); check("R1 status after reset", rd, 0);

      finish_run();
   end
endmodule